// File: doc/BRIEF.md
# Compare Timer with Auto-Increment Re-Arm

This block is a register-mapped event timer that observes a free-running 64-bit system count supplied from outside the block. It raises a status flag and an interrupt once that count reaches a programmed compare point. The timer keeps its own copy of the count. That copy follows the external value only on cycles where the external count-enable input is high.

There are two ways to set the compare point. In absolute mode software writes a 64-bit compare value. It may also write a 32-bit offset into a countdown register, and the compare point then becomes the current count plus that offset. In auto-increment mode the block keeps a 64-bit next-event value of its own. On each expiry it adds a 32-bit interval to that value, so the timer re-arms itself. In this mode the status flag is sticky: it stays set until software clears it with a write to the auto-increment control word.

The bus has 32-bit data and word addresses. Reads and writes complete on one clock edge, and read data is registered. Each 64-bit quantity appears as a low word and a high word.

Top module: `cmp_timer`

## Requirements
- R1: After reset, CTRL (word 0) reads 0, COUNT_LO (word 2) and COUNT_HI (word 3) read 0, and `irq` is 0.
- R2: The count view latches `sys_count` on every clock edge where `cnt_en` is 1, and holds its value while `cnt_en` is 0.
- R3: In CTRL, bit 0 is enable (read/write), bit 1 is interrupt mask (read/write) and bit 2 is the expired status (read-only; writes to it are ignored). An enabled, unmasked timer that has expired reads 5.
- R4: A read of DOWN (word 6) returns the compare value minus the count view, modulo 2^32. For example, compare 4000 at count 4000 reads 0 and compare 4000 at count 100 reads 3900.
- R5: With auto-increment off and the timer enabled, status equals the unsigned 64-bit test count >= compare (compare set through CMP_LO word 4 and CMP_HI word 5). It becomes valid on the cycle after the count view changes.
- R6: A write of value v to DOWN sets the compare value to the count view plus v, zero-extended to 64 bits.
- R7: A write to AUTO_CTL (word 8) with bit 0 = 1 while auto-increment is off loads the next-event value with count plus RELOAD (word 7) and clears status. A write with bit 0 = 1 while auto-increment is already on does not reload. A write with bit 0 = 0 turns auto-increment off.
- R8: With auto-increment on and the timer enabled, a count at or above the next-event value sets status and adds RELOAD to the next-event value.
- R9: In auto-increment mode, status stays set until a write to AUTO_CTL with bit 1 = 0. A write with bit 1 = 1 leaves it set.
- R10: The next-event value is 64 bits wide. It is read as AUTO_LO (word 9) and AUTO_HI (word 10), and a carry out of the low word reaches the high word.
- R11: `irq` is 1 exactly one cycle after enable = 1, mask = 0 and status = 1 all hold, and 0 otherwise.
- R12: Reads of word 1 and of words 11 to 15 return 0. Writes to the read-only words (COUNT_LO, COUNT_HI, AUTO_LO, AUTO_HI) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | System counter enable; the count view updates only while high |
| sys_count | input | 64 | Free-running system count value |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| waddr | input | 4 | Word address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| irq | output | 1 | Registered timer interrupt |

## Verification
A wrong next-event value or a lost carry shows up in the AUTO_LO and AUTO_HI words on the read after an arm or an expiry. It also moves the cycle in which status and `irq` rise. A status flag that is too eager or too sticky shows in CTRL bit 2 within two cycles of a count change or a clear write, and in `irq` one cycle after that. Stepping the count across expiry points in both modes, and placing the compare in a different high word than the count, exposes a faulty 64-bit comparison at the ports. A read or clear that reloads when it should not shows as a wrong AUTO_LO value.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  // Word indices of the register map
  localparam int WI_CTRL     = 0;
  localparam int WI_CNT_LO   = 2;
  localparam int WI_CNT_HI   = 3;
  localparam int WI_CMP_LO   = 4;
  localparam int WI_CMP_HI   = 5;
  localparam int WI_DOWN     = 6;
  localparam int WI_RELOAD   = 7;
  localparam int WI_AUTO_CTL = 8;
  localparam int WI_AUTO_LO  = 9;
  localparam int WI_AUTO_HI  = 10;
  localparam int WI_LAST     = WI_AUTO_HI;

  // Control word fields
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MASK_BIT = 1;
  localparam int CTRL_STAT_BIT = 2;
  // Auto-increment control word fields
  localparam int ACTL_ON_BIT   = 0;
  localparam int ACTL_KEEP_BIT = 1;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = 32,
  localparam int CW    = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     cnt_view,
  input  logic              status,
  input  logic [CW-1:0]     auto_val,
  output logic              en,
  output logic              mask,
  output logic [CW-1:0]     cmp,
  output logic [DW-1:0]     reload,
  output logic              auto_on,
  output logic              arm,
  output logic              clr,
  output logic [DW-1:0]     rdata
);
  logic          actl_wr;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] down_view;

  assign actl_wr   = wr_en && (int'(waddr) == WI_AUTO_CTL);
  assign arm       = actl_wr && wdata[ACTL_ON_BIT] && !auto_on;
  assign clr       = actl_wr && !wdata[ACTL_KEEP_BIT];
  assign down_view = cmp[DW-1:0] - cnt_view[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      mask    <= 1'b0;
      cmp     <= '0;
      reload  <= '0;
      auto_on <= 1'b0;
    end else if (wr_en) begin
      case (int'(waddr))
        WI_CTRL: begin
          en   <= wdata[CTRL_EN_BIT];
          mask <= wdata[CTRL_MASK_BIT];
        end
        WI_CMP_LO:   cmp[DW-1:0]  <= wdata;
        WI_CMP_HI:   cmp[CW-1:DW] <= wdata;
        WI_DOWN:     cmp          <= cnt_view + CW'(wdata);
        WI_RELOAD:   reload       <= wdata;
        WI_AUTO_CTL: auto_on      <= wdata[ACTL_ON_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(waddr))
      WI_CTRL: begin
        rd_mux[CTRL_EN_BIT]   = en;
        rd_mux[CTRL_MASK_BIT] = mask;
        rd_mux[CTRL_STAT_BIT] = status;
      end
      WI_CNT_LO:   rd_mux = cnt_view[DW-1:0];
      WI_CNT_HI:   rd_mux = cnt_view[CW-1:DW];
      WI_CMP_LO:   rd_mux = cmp[DW-1:0];
      WI_CMP_HI:   rd_mux = cmp[CW-1:DW];
      WI_DOWN:     rd_mux = down_view;
      WI_RELOAD:   rd_mux = reload;
      WI_AUTO_CTL: rd_mux[ACTL_ON_BIT] = auto_on;
      WI_AUTO_LO:  rd_mux = auto_val[DW-1:0];
      WI_AUTO_HI:  rd_mux = auto_val[CW-1:DW];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end
endmodule

// File: rtl/cmp_timer_abscmp.sv
module cmp_timer_abscmp #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [CW-1:0] cnt_view,
  input  logic [CW-1:0] cmp,
  output logic          flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= active && (cnt_view >= cmp);
  end
endmodule

// File: rtl/cmp_timer_autoinc.sv
module cmp_timer_autoinc #(
  parameter int DW  = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          arm,
  input  logic          clr,
  input  logic [CW-1:0] cnt_view,
  input  logic [DW-1:0] reload,
  output logic [CW-1:0] auto_val,
  output logic          flag
);
  logic          hit;
  logic [CW-1:0] step;

  assign step = CW'(reload);
  assign hit  = active && (cnt_view >= auto_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_val <= '0;
      flag     <= 1'b0;
    end else if (arm) begin
      auto_val <= cnt_view + step;
      flag     <= 1'b0;
    end else if (hit) begin
      auto_val <= auto_val + step;
      flag     <= 1'b1;
    end else if (clr) begin
      flag     <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int ADDR_W = 4,
  parameter int DW     = 32,
  localparam int CW    = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic [CW-1:0]     sys_count,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  logic [CW-1:0] cnt_view;
  logic [CW-1:0] cmp;
  logic [CW-1:0] auto_val;
  logic [DW-1:0] reload;
  logic          en, mask, auto_on, arm, clr;
  logic          abs_flag, auto_flag, status;

  always_ff @(posedge clk) begin
    if (rst)         cnt_view <= '0;
    else if (cnt_en) cnt_view <= sys_count;
  end

  cmp_timer_regs #(.ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr),
    .wdata(wdata), .cnt_view(cnt_view), .status(status), .auto_val(auto_val),
    .en(en), .mask(mask), .cmp(cmp), .reload(reload), .auto_on(auto_on),
    .arm(arm), .clr(clr), .rdata(rdata)
  );

  cmp_timer_abscmp #(.CW(CW)) u_abs (
    .clk(clk), .rst(rst), .active(en && !auto_on), .cnt_view(cnt_view),
    .cmp(cmp), .flag(abs_flag)
  );

  cmp_timer_autoinc #(.DW(DW)) u_auto (
    .clk(clk), .rst(rst), .active(en && auto_on), .arm(arm), .clr(clr),
    .cnt_view(cnt_view), .reload(reload), .auto_val(auto_val), .flag(auto_flag)
  );

  assign status = auto_on ? auto_flag : abs_flag;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en && !mask && status;
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = 32,
  parameter int CW     = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] waddr,
  input logic [DW-1:0]     rdata,
  input logic              irq,
  input logic [CW-1:0]     cnt_view,
  input logic [CW-1:0]     auto_val,
  input logic [DW-1:0]     reload,
  input logic              en,
  input logic              mask,
  input logic              status,
  input logic              auto_on,
  input logic              auto_flag,
  input logic              arm
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq && rdata == '0));

  a_r2_hold_count: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt_view));

  a_r7_arm_load: assert property (@(posedge clk) disable iff (rst)
    arm |=> (auto_val == $past(cnt_view) + CW'($past(reload)) && !auto_flag));

  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (auto_on && en && !arm && cnt_view >= auto_val)
      |=> (auto_flag && auto_val == $past(auto_val) + CW'($past(reload))));

  a_r11_irq_on: assert property (@(posedge clk) disable iff (rst)
    (en && !mask && status) |=> irq);

  a_r11_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(en && !mask && status) |=> !irq);

  a_r12_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (int'(waddr) == 1 || int'(waddr) > WI_LAST)) |=> rdata == '0);
endmodule

bind cmp_timer cmp_timer_chk #(.ADDR_W(ADDR_W), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .rd_en(rd_en), .waddr(waddr),
  .rdata(rdata), .irq(irq), .cnt_view(cnt_view), .auto_val(auto_val),
  .reload(reload), .en(en), .mask(mask), .status(status), .auto_on(auto_on),
  .auto_flag(auto_flag), .arm(arm)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic [63:0] sys_count = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int CTRL = 0, CNT_LO = 2, CNT_HI = 3, CMP_LO = 4, CMP_HI = 5,
                 DOWN = 6, RELOAD = 7, ACTL = 8, AUTO_LO = 9, AUTO_HI = 10;

  always #10 clk = ~clk;

  cmp_timer dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .sys_count(sys_count),
    .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; waddr = 4'(a);
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, {32'b0, d}, {32'b0, exp});
  endtask

  task automatic set_count(input logic [63:0] v);
    @(negedge clk);
    sys_count = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", CTRL, 0);
    rd_chk("R1 count lo", CNT_LO, 0);
    rd_chk("R1 count hi", CNT_HI, 0);
    chk("R1 irq", {63'b0, irq}, 0);
  endtask

  task automatic t_count;
    @(negedge clk); cnt_en = 1'b1;
    set_count(64'd100);
    rd_chk("R2 tracks", CNT_LO, 100);
    @(negedge clk); cnt_en = 1'b0;
    set_count(64'd500);
    rd_chk("R2 holds", CNT_LO, 100);
    @(negedge clk); cnt_en = 1'b1;
    set_count(64'd100);
  endtask

  task automatic t_abs;
    wr(CTRL, 32'h1);
    wr(CMP_LO, 32'd4000);
    wr(CMP_HI, 32'd0);
    rd_chk("R4 down 3900", DOWN, 3900);
    rd_chk("R3 enabled idle", CTRL, 1);
    chk("R11 irq idle", {63'b0, irq}, 0);
    set_count(64'd4000);
    rd_chk("R4 down zero", DOWN, 0);
    rd_chk("R3 R5 expired", CTRL, 5);
    chk("R11 irq fires", {63'b0, irq}, 1);
    wr(CTRL, 32'h3);
    repeat (2) @(negedge clk);
    chk("R11 masked", {63'b0, irq}, 0);
    rd_chk("R3 masked read", CTRL, 7);
    wr(CTRL, 32'h1);
    rd_chk("R3 status read-only", CTRL, 5);
    wr(CMP_HI, 32'd1);
    repeat (2) @(negedge clk);
    rd_chk("R5 high word pending", CTRL, 1);
    set_count(64'h0000_0000_FFFF_FFFF);
    rd_chk("R5 low word larger", CTRL, 1);
    set_count(64'h0000_0001_0000_1000);
    rd_chk("R5 high word reached", CTRL, 5);
    wr(CMP_HI, 32'd0);
    set_count(64'd4000);
  endtask

  task automatic t_down_write;
    wr(DOWN, 32'd50);
    rd_chk("R6 cmp lo", CMP_LO, 4050);
    rd_chk("R6 cmp hi", CMP_HI, 0);
    repeat (2) @(negedge clk);
    rd_chk("R6 not yet", CTRL, 1);
  endtask

  task automatic t_auto;
    wr(RELOAD, 32'd200);
    wr(ACTL, 32'h1);
    rd_chk("R7 load lo", AUTO_LO, 4200);
    rd_chk("R7 load hi", AUTO_HI, 0);
    rd_chk("R7 status cleared", CTRL, 1);
    set_count(64'd4100);
    rd_chk("R8 before point", CTRL, 1);
    set_count(64'd4200);
    rd_chk("R8 fires", CTRL, 5);
    rd_chk("R8 advance", AUTO_LO, 4400);
    set_count(64'd4300);
    rd_chk("R9 sticky", CTRL, 5);
    wr(ACTL, 32'h3);
    rd_chk("R9 keep bit", CTRL, 5);
    rd_chk("R7 no reload", AUTO_LO, 4400);
    wr(ACTL, 32'h1);
    rd_chk("R9 cleared", CTRL, 1);
    set_count(64'd4400);
    rd_chk("R8 fires again", CTRL, 5);
    rd_chk("R8 second advance", AUTO_LO, 4600);
  endtask

  task automatic t_carry;
    wr(ACTL, 32'h0);
    set_count(64'h0000_0042_0000_1130);
    rd_chk("R2 count hi", CNT_HI, 32'h42);
    wr(ACTL, 32'h1);
    rd_chk("R10 lo", AUTO_LO, 4600);
    rd_chk("R10 hi", AUTO_HI, 32'h42);
    wr(ACTL, 32'h0);
    set_count(64'h0000_0000_FFFF_FFF0);
    wr(RELOAD, 32'h20);
    wr(ACTL, 32'h1);
    rd_chk("R10 carry lo", AUTO_LO, 32'h10);
    rd_chk("R10 carry hi", AUTO_HI, 32'h1);
  endtask

  task automatic t_undef;
    rd_chk("R12 word 1", 1, 0);
    rd_chk("R12 word 15", 15, 0);
    wr(CNT_LO, 32'h1234);
    rd_chk("R12 ro count", CNT_LO, 32'hFFFF_FFF0);
    wr(AUTO_LO, 32'h1234);
    rd_chk("R12 ro auto", AUTO_LO, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_abs();
    t_down_write();
    t_auto();
    t_carry();
    t_undef();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule